// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block produces the address sequence for a synchronous burst memory. On a clock edge where a burst is started, it captures an external address. Later beats of the burst keep the upper address bits and derive the low bits from a small beat counter. The counter moves one step only in cycles where the advance input is high. A new start may come in any cycle, even in the middle of a burst, so a caller may present a fresh address every cycle and never use bursting.

A burst can be started from two sides. The processor-side strobe counts only while the chip enable is high. The controller-side strobe is always honoured. A mode input selects the order of the low bits. In linear order they count up and wrap. In interleaved order they are the starting bits XOR the beat count. The order is sampled at the start of each burst. Both outputs are registered: the full current address and the beat index.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o and beat_o are zero. The burst order held after reset is interleaved.
- R2: With linear order (order_lin_i high at the start), the low BEAT_W address bits equal the starting low bits plus beat_o, modulo 2^BEAT_W. The upper bits equal the captured address.
- R3: With interleaved order (order_lin_i low at the start, which is also the default level), the low bits equal the starting low bits XOR beat_o. The upper bits equal the captured address.
- R4: A start loads in the clock edge that samples it, in any cycle, including mid-burst. A start is ctl_start_i high, or cpu_start_i high together with ce_i high. After that edge, addr_o equals the sampled addr_i and beat_o is 0.
- R5: With no start and adv_i high, beat_o increases by one, modulo 2^BEAT_W, at the edge.
- R6: With no start and adv_i low, addr_o and beat_o keep their values.
- R7: cpu_start_i has no effect while ce_i is low. In that case ctl_start_i or adv_i alone decides the next state. When both strobes load together, a single load from addr_i takes place.
- R8: order_lin_i is sampled only at a start. Changing it during a burst does not change the addresses of that burst.
- R9: After the last beat, an advance wraps beat_o to 0 and addr_o back to the starting address. The upper bits never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable; gates the processor-side strobe |
| cpu_start_i | input | 1 | Processor-side burst start |
| ctl_start_i | input | 1 | Controller-side burst start |
| adv_i | input | 1 | Advance the burst by one beat |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | BEAT_W | Beat index within the burst |

## Verification
The hardest case to reach is a processor strobe while ce_i is low. It has to arrive together with a controller strobe or an advance, and a burst must already be under way, so that the gating is visible in the next state. The stimulus builds that case on purpose: it first runs part of a burst, then drives each of these combinations for one cycle. It also toggles order_lin_i in the middle of a burst to show that the order was latched at the start. A long random phase compares every cycle against the reference model in the bench.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_ord_e;
endpackage

// File: rtl/bag_arb.sv
module bag_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic cpu_start_i,
  input  logic ctl_start_i,
  input  logic adv_i,
  output logic load_o,
  output logic step_o,
  output logic sel_cpu_o
);
  logic cpu_go;

  always_comb begin
    cpu_go    = cpu_start_i & ce_i;
    sel_cpu_o = cpu_go;               // processor side has priority
    load_o    = cpu_go | ctl_start_i;
    step_o    = adv_i & ~load_o;
  end

  a_r7_gated_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !ctl_start_i) |-> !load_o);
  a_r4_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> !step_o);
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LastBeat = {BEAT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (step_i) beat_o <= beat_o + 1'b1;
  end

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && beat_o == LastBeat) |=> beat_o == '0);
  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> beat_o == $past(beat_o) + 1'b1);
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_ord_e        ord_i,
  input  logic [BEAT_W-1:0] start_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] lo_o
);
  logic [BEAT_W-1:0] lin_lo, ilv_lo;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_lo_i[b] ^ beat_i[b];
  end

  assign lin_lo = start_lo_i + beat_i;
  assign lo_o   = (ord_i == ORD_LINEAR) ? lin_lo : ilv_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              cpu_start_i,
  input  logic              ctl_start_i,
  input  logic              adv_i,
  input  logic              order_lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load, step, sel_cpu;
  logic [ADDR_W-1:0] base_q;
  burst_ord_e        ord_q;
  logic [BEAT_W-1:0] lo_d, beat_d;

  bag_arb u_arb (
    .clk_i, .rst_ni, .ce_i, .cpu_start_i, .ctl_start_i, .adv_i,
    .load_o(load), .step_o(step), .sel_cpu_o(sel_cpu)
  );

  bag_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .beat_o(beat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ord_q  <= ORD_INTLV;
    end else if (load) begin
      base_q <= addr_i;
      ord_q  <= order_lin_i ? ORD_LINEAR : ORD_INTLV;
    end
  end

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .ord_i(ord_q), .start_lo_i(base_q[BEAT_W-1:0]), .beat_i(beat_d), .lo_o(lo_d)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], lo_d};
  assign beat_o = beat_d;

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (addr_o == $past(addr_i) && beat_o == '0));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !adv_i) |=> ($stable(addr_o) && $stable(beat_o)));
  a_r9_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  a_r7_cpu_only_when_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cpu |-> ce_i);
  a_r2_hi_width: assert property (@(posedge clk_i) HI_W > 0);
endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int AW = 20;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic clk = 0, rst_n = 0;
  logic ce = 0, cpu_st = 0, ctl_st = 0, adv = 0, ord_lin = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [BW-1:0] beat_out;

  int total = 0, bad = 0;
  int m_base = 0, m_beat = 0, m_lin = 0;

  always #2 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cpu_start_i(cpu_st),
    .ctl_start_i(ctl_st), .adv_i(adv), .order_lin_i(ord_lin),
    .addr_i(addr_in), .addr_o(addr_out), .beat_o(beat_out)
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int exp_addr();
    int lo;
    lo = m_lin ? ((m_base + m_beat) % NB) : ((m_base % NB) ^ m_beat);
    return (m_base & ~(NB - 1)) | lo;
  endfunction

  // drive at negedge, update model, compare after the edge
  task automatic cyc(bit c, bit cs, bit ks, bit a, bit ol, int ad);
    string req;
    @(negedge clk);
    ce = c; cpu_st = cs; ctl_st = ks; adv = a; ord_lin = ol; addr_in = AW'(ad);
    if ((cs && c) || ks) begin
      m_base = ad & ((1 << AW) - 1); m_beat = 0; m_lin = ol; req = "R4";
    end else if (a) begin
      req = (m_beat == NB - 1) ? "R9" : (m_lin ? "R2" : "R3");
      m_beat = (m_beat + 1) % NB;
    end else req = "R6";
    if (cs && !c) req = "R7";
    @(posedge clk); #1;
    chk({req, " addr"}, int'(addr_out), exp_addr());
    chk({req, " beat R5"}, int'(beat_out), m_beat);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    chk("R1 addr", int'(addr_out), 0);
    chk("R1 beat", int'(beat_out), 0);
    @(negedge clk); rst_n = 1;
    // R3 default interleaved after reset, advance from zero base
    cyc(0,0,0,1,1,0);
    // R2 linear burst starting at low bits 1, full wrap (R9)
    cyc(1,1,0,0,1,'h3A5D1);
    for (int i = 0; i < 5; i++) cyc(0,0,0,1,0,0);
    // R3 interleaved from low bits 2 via controller strobe
    cyc(0,0,1,0,0,'h12346);
    for (int i = 0; i < 3; i++) begin cyc(0,0,0,1,1,0); cyc(1,0,0,0,1,'h55); end
    // R8 order flip mid-burst has no effect
    cyc(1,1,0,1,1,'h0FF03);
    cyc(0,0,0,1,0,0); cyc(0,0,0,1,1,0); cyc(0,0,0,1,0,0);
    // R4 reload mid-burst, back-to-back loads
    cyc(0,0,1,1,0,'hABCDE); cyc(1,1,1,1,1,'h00011); cyc(1,1,0,0,0,'h77772);
    // R7 processor strobe ignored while disabled
    cyc(0,0,0,1,1,0);
    cyc(0,1,0,1,0,'h99999);
    cyc(0,1,0,0,1,'h88888);
    cyc(0,1,1,1,1,'h44441);
    cyc(0,1,0,1,0,'h22222);
    // random phase
    for (int i = 0; i < 2000; i++)
      cyc($urandom_range(0,1), ($urandom_range(0,5) == 0), ($urandom_range(0,7) == 0),
          $urandom_range(0,1), $urandom_range(0,1), int'($urandom_range(0, (1 << AW) - 1)));
    // R1 asynchronous reset mid-burst
    @(negedge clk); rst_n = 0; #1;
    chk("R1 addr async", int'(addr_out), 0);
    chk("R1 beat async", int'(beat_out), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule